// File: doc/BRIEF.md
# Track Cache Tag and LFU Replacement Engine

This block keeps the tags and replacement state of a second-level cache that holds a few large lines, one disk track per line. All entries are searched at once on every lookup, so any track may sit in any entry. A lookup returns a registered hit or miss and, on a hit, the entry number. Each hit also bumps a saturating use counter for the entry and sets a bit in a per-entry map that records which sector-sized sub-blocks of the track have been touched.

When the first level misses in this cache, the requester asks for a placement. The engine prefers an empty entry. With none empty, it evicts the least-used entry among those that still match the disk. It returns the evicted tag and its touched sub-block map, so that the caller can move those sub-blocks up a level. It then holds the entry in a filling state while the whole track is prefetched. Lines written back from the first level are marked dirty and cannot be evicted until the disk write is reported complete. If no entry can be evicted, the placement request is answered with busy.

Top module: `track_lfu_tagger`

## Requirements
- R1: After reset every entry is empty, all outputs are 0, and a lookup of any tag misses.
- R2: A lookup presented in cycle n is answered in cycle n+1 with exactly one of `lk_hit` or `lk_miss`. On a hit, `lk_idx` is the entry holding that tag. On a miss, `lk_idx` is 0. Only clean or dirty entries can hit.
- R3: A placement request while an empty entry exists is granted the lowest-numbered empty entry, with `evict_valid` = 0.
- R4: With no empty entry, the victim is the clean entry with the smallest use count. Equal counts go to the lowest index. `evict_valid` = 1, and `evict_tag` and `evict_map` carry the old tag and the old sub-block map.
- R5: A dirty entry is never chosen. A request that finds no empty or clean entry gets `alloc_busy` = 1 and `alloc_grant` = 0, and no entry changes.
- R6: A completed disk write (`clean_valid`) returns a dirty entry to clean and makes it eligible again. If the mark-dirty and clean inputs name the same entry in the same cycle, the entry stays dirty.
- R7: A newly placed entry starts with a use count of 1. Each hit adds 1, and the count saturates at 2^FREQ_W-1 (7 by default).
- R8: A hit sets bit `lk_sub` of the entry's sub-block map. Bit k stands for sub-block k. The map is cleared when the entry is placed.
- R9: An entry that has been granted but not yet marked filled (`fill_valid`) neither hits nor can be chosen as a victim.
- R10: A lookup and a placement in the same cycle both see the entry state from before that cycle. The placement overwrites the victim, including any counter or map update from that lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_tag | input | TAG_W | Track tag to search |
| lk_sub | input | SUB_W | Sub-block touched by this lookup |
| lk_hit | output | 1 | Registered hit |
| lk_miss | output | 1 | Registered miss |
| lk_idx | output | IDX_W | Entry that hit |
| alloc_req | input | 1 | Placement request |
| alloc_tag | input | TAG_W | Tag of the track to place |
| alloc_grant | output | 1 | Placement granted |
| alloc_busy | output | 1 | No evictable entry |
| alloc_idx | output | IDX_W | Entry granted |
| evict_valid | output | 1 | A valid clean track was evicted |
| evict_tag | output | TAG_W | Tag of the evicted track |
| evict_map | output | 2^SUB_W | Touched sub-blocks of the evicted track |
| fill_valid | input | 1 | Track prefetch finished |
| fill_idx | input | IDX_W | Entry whose prefetch finished |
| dirty_valid | input | 1 | Write-back from first level landed |
| dirty_idx | input | IDX_W | Entry made dirty |
| clean_valid | input | 1 | Disk write of an entry finished |
| clean_idx | input | IDX_W | Entry now consistent with disk |

## Verification
Two pairs of operations can land in the same cycle, and both are provoked directly. In the first, a lookup hits the very entry that a placement evicts in that cycle. The bench expects the hit to be reported, the eviction to show the map from before that cycle, and a repeat lookup to miss. In the second, mark-dirty and clean arrive for the same entry together while every other entry is dirty. The follow-up placement must answer busy, which shows that the dirty mark won.

// File: rtl/tbt_pkg.sv
package tbt_pkg;

    typedef enum logic [1:0] {
        LN_FREE  = 2'd0,
        LN_FILL  = 2'd1,
        LN_CLEAN = 2'd2,
        LN_DIRTY = 2'd3
    } line_state_e;

endpackage

// File: rtl/tbt_tag_match.sv
module tbt_tag_match #(
    parameter int unsigned ENTRIES = 4,
    parameter int unsigned TAG_W   = 16,
    parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
    input  logic [ENTRIES-1:0]            live,
    input  logic [TAG_W-1:0]              key,
    output logic                          hit,
    output logic [IDX_W-1:0]              idx
);

    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = live[g] && (tags[g] == key);
    end

    always_comb begin
        hit = |match;
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tbt_victim_sel.sv
module tbt_victim_sel #(
    parameter int unsigned ENTRIES = 4,
    parameter int unsigned FREQ_W  = 3,
    parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]             free_mask,
    input  logic [ENTRIES-1:0]             clean_mask,
    input  logic [ENTRIES-1:0][FREQ_W-1:0] counts,
    output logic                           found,
    output logic                           use_free,
    output logic [IDX_W-1:0]               idx
);

    logic [FREQ_W-1:0] best;

    always_comb begin
        found    = 1'b0;
        use_free = 1'b0;
        idx      = '0;
        best     = '1;
        // lowest-numbered empty entry first
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (free_mask[i]) begin
                found    = 1'b1;
                use_free = 1'b1;
                idx      = IDX_W'(i);
            end
        end
        // otherwise least count among clean entries; strict compare keeps lowest index on ties
        if (!use_free) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (clean_mask[i] && (!found || counts[i] < best)) begin
                    found = 1'b1;
                    best  = counts[i];
                    idx   = IDX_W'(i);
                end
            end
        end
    end

endmodule

// File: rtl/track_lfu_tagger.sv
module track_lfu_tagger
    import tbt_pkg::*;
#(
    parameter int unsigned ENTRIES = 4,
    parameter int unsigned TAG_W   = 16,
    parameter int unsigned SUB_W   = 3,
    parameter int unsigned FREQ_W  = 3,
    parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lk_valid,
    input  logic [TAG_W-1:0]      lk_tag,
    input  logic [SUB_W-1:0]      lk_sub,
    output logic                  lk_hit,
    output logic                  lk_miss,
    output logic [IDX_W-1:0]      lk_idx,
    input  logic                  alloc_req,
    input  logic [TAG_W-1:0]      alloc_tag,
    output logic                  alloc_grant,
    output logic                  alloc_busy,
    output logic [IDX_W-1:0]      alloc_idx,
    output logic                  evict_valid,
    output logic [TAG_W-1:0]      evict_tag,
    output logic [(1<<SUB_W)-1:0] evict_map,
    input  logic                  fill_valid,
    input  logic [IDX_W-1:0]      fill_idx,
    input  logic                  dirty_valid,
    input  logic [IDX_W-1:0]      dirty_idx,
    input  logic                  clean_valid,
    input  logic [IDX_W-1:0]      clean_idx
);

    localparam int unsigned SUBS = 1 << SUB_W;
    localparam logic [FREQ_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        line_state_e       st;
        logic [TAG_W-1:0]  tag;
        logic [FREQ_W-1:0] cnt;
        logic [SUBS-1:0]   seen;
    } line_t;

    typedef struct packed {
        line_t [ENTRIES-1:0] line;
        logic                lk_hit;
        logic                lk_miss;
        logic [IDX_W-1:0]    lk_idx;
        logic                grant;
        logic                busy;
        logic [IDX_W-1:0]    a_idx;
        logic                ev_valid;
        logic [TAG_W-1:0]    ev_tag;
        logic [SUBS-1:0]     ev_map;
    } regs_t;

    regs_t r_q, r_d;

    logic [ENTRIES-1:0][TAG_W-1:0]  tag_vec;
    logic [ENTRIES-1:0][FREQ_W-1:0] cnt_vec;
    logic [ENTRIES-1:0]             live_mask, free_mask, clean_mask;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_view
        assign tag_vec[g]    = r_q.line[g].tag;
        assign cnt_vec[g]    = r_q.line[g].cnt;
        assign free_mask[g]  = (r_q.line[g].st == LN_FREE);
        assign clean_mask[g] = (r_q.line[g].st == LN_CLEAN);
        assign live_mask[g]  = (r_q.line[g].st == LN_CLEAN) || (r_q.line[g].st == LN_DIRTY);
    end

    logic             m_hit;
    logic [IDX_W-1:0] m_idx;
    logic             v_found, v_free;
    logic [IDX_W-1:0] v_idx;

    tbt_tag_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_match (
        .tags (tag_vec),
        .live (live_mask),
        .key  (lk_tag),
        .hit  (m_hit),
        .idx  (m_idx)
    );

    tbt_victim_sel #(.ENTRIES(ENTRIES), .FREQ_W(FREQ_W), .IDX_W(IDX_W)) u_victim (
        .free_mask  (free_mask),
        .clean_mask (clean_mask),
        .counts     (cnt_vec),
        .found      (v_found),
        .use_free   (v_free),
        .idx        (v_idx)
    );

    always_comb begin
        r_d          = r_q;
        r_d.lk_hit   = 1'b0;
        r_d.lk_miss  = 1'b0;
        r_d.lk_idx   = '0;
        r_d.grant    = 1'b0;
        r_d.busy     = 1'b0;
        r_d.a_idx    = '0;
        r_d.ev_valid = 1'b0;
        r_d.ev_tag   = '0;
        r_d.ev_map   = '0;

        if (lk_valid) begin
            r_d.lk_hit  = m_hit;
            r_d.lk_miss = !m_hit;
            if (m_hit) begin
                r_d.lk_idx = m_idx;
                if (r_q.line[m_idx].cnt != CNT_MAX) begin
                    r_d.line[m_idx].cnt = r_q.line[m_idx].cnt + FREQ_W'(1);
                end
                r_d.line[m_idx].seen[lk_sub] = 1'b1;
            end
        end

        for (int i = 0; i < ENTRIES; i++) begin
            if (clean_valid && clean_idx == IDX_W'(i) && r_q.line[i].st == LN_DIRTY) begin
                r_d.line[i].st = LN_CLEAN;
            end
            if (fill_valid && fill_idx == IDX_W'(i) && r_q.line[i].st == LN_FILL) begin
                r_d.line[i].st = LN_CLEAN;
            end
            // a fresh write-back outranks a disk-write completion
            if (dirty_valid && dirty_idx == IDX_W'(i) &&
                (r_q.line[i].st == LN_CLEAN || r_q.line[i].st == LN_DIRTY)) begin
                r_d.line[i].st = LN_DIRTY;
            end
        end

        if (alloc_req) begin
            if (v_found) begin
                r_d.grant    = 1'b1;
                r_d.a_idx    = v_idx;
                r_d.ev_valid = !v_free;
                if (!v_free) begin
                    r_d.ev_tag = r_q.line[v_idx].tag;
                    r_d.ev_map = r_q.line[v_idx].seen;
                end
                r_d.line[v_idx].st   = LN_FILL;
                r_d.line[v_idx].tag  = alloc_tag;
                r_d.line[v_idx].cnt  = FREQ_W'(1);
                r_d.line[v_idx].seen = '0;
            end else begin
                r_d.busy = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign lk_hit      = r_q.lk_hit;
    assign lk_miss     = r_q.lk_miss;
    assign lk_idx      = r_q.lk_idx;
    assign alloc_grant = r_q.grant;
    assign alloc_busy  = r_q.busy;
    assign alloc_idx   = r_q.a_idx;
    assign evict_valid = r_q.ev_valid;
    assign evict_tag   = r_q.ev_tag;
    assign evict_map   = r_q.ev_map;

endmodule

// File: rtl/tbt_checker.sv
module tbt_checker #(
    parameter int unsigned IDX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic             lk_hit,
    input logic             lk_miss,
    input logic [IDX_W-1:0] lk_idx,
    input logic             alloc_req,
    input logic             alloc_grant,
    input logic             alloc_busy,
    input logic             evict_valid
);

    p_one_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (lk_hit != lk_miss));

    p_quiet_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!lk_hit && !lk_miss));

    p_miss_idx_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |-> (lk_idx == '0));

    p_alloc_answer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req |=> (alloc_grant != alloc_busy));

    p_alloc_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc_req |=> (!alloc_grant && !alloc_busy));

    p_evict_with_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |-> alloc_grant);

endmodule

bind track_lfu_tagger tbt_checker #(.IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_valid    (lk_valid),
    .lk_hit      (lk_hit),
    .lk_miss     (lk_miss),
    .lk_idx      (lk_idx),
    .alloc_req   (alloc_req),
    .alloc_grant (alloc_grant),
    .alloc_busy  (alloc_busy),
    .evict_valid (evict_valid)
);

// File: tb/track_lfu_tagger_bench.sv
module track_lfu_tagger_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [15:0] lk_tag = '0;
    logic [2:0]  lk_sub = '0;
    logic        lk_hit, lk_miss;
    logic [1:0]  lk_idx;
    logic        alloc_req = 1'b0;
    logic [15:0] alloc_tag = '0;
    logic        alloc_grant, alloc_busy;
    logic [1:0]  alloc_idx;
    logic        evict_valid;
    logic [15:0] evict_tag;
    logic [7:0]  evict_map;
    logic        fill_valid = 1'b0;
    logic [1:0]  fill_idx = '0;
    logic        dirty_valid = 1'b0;
    logic [1:0]  dirty_idx = '0;
    logic        clean_valid = 1'b0;
    logic [1:0]  clean_idx = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    track_lfu_tagger u_track_lfu_tagger (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_sub(lk_sub),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_idx(lk_idx),
        .alloc_req(alloc_req), .alloc_tag(alloc_tag),
        .alloc_grant(alloc_grant), .alloc_busy(alloc_busy), .alloc_idx(alloc_idx),
        .evict_valid(evict_valid), .evict_tag(evict_tag), .evict_map(evict_map),
        .fill_valid(fill_valid), .fill_idx(fill_idx),
        .dirty_valid(dirty_valid), .dirty_idx(dirty_idx),
        .clean_valid(clean_valid), .clean_idx(clean_idx)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_lookup(input logic [15:0] t, input logic [2:0] s,
                             input logic exp_hit, input logic [1:0] exp_idx, input string req);
        lk_valid = 1'b1; lk_tag = t; lk_sub = s;
        @(negedge clk);
        lk_valid = 1'b0;
        check(req, "lk_hit", 32'(lk_hit), 32'(exp_hit));
        check(req, "lk_miss", 32'(lk_miss), 32'(!exp_hit));
        check(req, "lk_idx", 32'(lk_idx), exp_hit ? 32'(exp_idx) : 32'd0);
    endtask

    task automatic quiet_hits(input logic [15:0] t, input int n);
        for (int k = 0; k < n; k++) begin
            lk_valid = 1'b1; lk_tag = t; lk_sub = 3'd0;
            @(negedge clk);
        end
        lk_valid = 1'b0;
    endtask

    task automatic do_alloc(input logic [15:0] t, input logic exp_grant, input logic [1:0] exp_idx,
                            input logic exp_ev, input logic [15:0] exp_tag, input logic [7:0] exp_map,
                            input string req);
        alloc_req = 1'b1; alloc_tag = t;
        @(negedge clk);
        alloc_req = 1'b0;
        check(req, "alloc_grant", 32'(alloc_grant), 32'(exp_grant));
        check(req, "alloc_busy", 32'(alloc_busy), 32'(!exp_grant));
        if (exp_grant) begin
            check(req, "alloc_idx", 32'(alloc_idx), 32'(exp_idx));
            check(req, "evict_valid", 32'(evict_valid), 32'(exp_ev));
            if (exp_ev) begin
                check(req, "evict_tag", 32'(evict_tag), 32'(exp_tag));
                check(req, "evict_map", 32'(evict_map), 32'(exp_map));
            end
        end
    endtask

    task automatic do_fill(input logic [1:0] i);
        fill_valid = 1'b1; fill_idx = i; @(negedge clk); fill_valid = 1'b0;
    endtask

    task automatic do_dirty(input logic [1:0] i);
        dirty_valid = 1'b1; dirty_idx = i; @(negedge clk); dirty_valid = 1'b0;
    endtask

    task automatic do_clean(input logic [1:0] i);
        clean_valid = 1'b1; clean_idx = i; @(negedge clk); clean_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "lk_hit at reset", 32'(lk_hit), 0);
        check("R1", "alloc_grant at reset", 32'(alloc_grant), 0);
        check("R1", "evict_valid at reset", 32'(evict_valid), 0);
        do_lookup(16'h0000, 3'd0, 1'b0, 2'd0, "R1");
    endtask

    task automatic t_place_empty();
        do_alloc(16'h0010, 1'b1, 2'd0, 1'b0, '0, '0, "R3");
        do_lookup(16'h0010, 3'd0, 1'b0, 2'd0, "R9 filling entry misses");
        do_alloc(16'h0011, 1'b1, 2'd1, 1'b0, '0, '0, "R3");
        do_alloc(16'h0012, 1'b1, 2'd2, 1'b0, '0, '0, "R3");
        do_alloc(16'h0013, 1'b1, 2'd3, 1'b0, '0, '0, "R3");
        for (int i = 0; i < 4; i++) do_fill(2'(i));
    endtask

    task automatic t_hit();
        do_lookup(16'h0012, 3'd5, 1'b1, 2'd2, "R2");
        do_lookup(16'h0099, 3'd0, 1'b0, 2'd0, "R2");
    endtask

    task automatic t_lfu();
        // counts: e0=3, e1=2 (map bit3), e2=2 (map bit5), e3=2
        quiet_hits(16'h0010, 2);
        do_lookup(16'h0011, 3'd3, 1'b1, 2'd1, "R8");
        quiet_hits(16'h0013, 1);
        do_alloc(16'h0020, 1'b1, 2'd1, 1'b1, 16'h0011, 8'h08, "R4 tie lowest index");
        do_fill(2'd1);
    endtask

    task automatic t_dirty_skip();
        do_dirty(2'd1);
        do_alloc(16'h0021, 1'b1, 2'd2, 1'b1, 16'h0012, 8'h20, "R5 dirty skipped");
        do_fill(2'd2);
    endtask

    task automatic t_busy();
        do_dirty(2'd0); do_dirty(2'd2); do_dirty(2'd3);
        do_alloc(16'h0030, 1'b0, '0, '0, '0, '0, "R5 all dirty");
        do_lookup(16'h0021, 3'd0, 1'b1, 2'd2, "R5 state kept");
    endtask

    task automatic t_dirty_vs_clean();
        dirty_valid = 1'b1; dirty_idx = 2'd3; clean_valid = 1'b1; clean_idx = 2'd3;
        @(negedge clk);
        dirty_valid = 1'b0; clean_valid = 1'b0;
        do_alloc(16'h0031, 1'b0, '0, '0, '0, '0, "R6 dirty wins");
        do_clean(2'd2);
        do_alloc(16'h0040, 1'b1, 2'd2, 1'b1, 16'h0021, 8'h01, "R6 R8 cleaned entry evicted, map fresh");
        do_lookup(16'h0040, 3'd0, 1'b0, 2'd0, "R9 miss while filling");
        do_alloc(16'h0041, 1'b0, '0, '0, '0, '0, "R9 filling not victim");
        do_fill(2'd2);
    endtask

    task automatic t_saturate();
        do_clean(2'd1);
        quiet_hits(16'h0020, 6);
        quiet_hits(16'h0040, 10);
        do_alloc(16'h0050, 1'b1, 2'd1, 1'b1, 16'h0020, 8'h01, "R7 saturation tie");
        do_fill(2'd1);
    endtask

    task automatic t_collide();
        lk_valid = 1'b1; lk_tag = 16'h0050; lk_sub = 3'd2;
        alloc_req = 1'b1; alloc_tag = 16'h0060;
        @(negedge clk);
        lk_valid = 1'b0; alloc_req = 1'b0;
        check("R10", "lk_hit", 32'(lk_hit), 1);
        check("R10", "lk_idx", 32'(lk_idx), 1);
        check("R10", "alloc_grant", 32'(alloc_grant), 1);
        check("R10", "alloc_idx", 32'(alloc_idx), 1);
        check("R10", "evict_tag", 32'(evict_tag), 32'h50);
        check("R10", "evict_map", 32'(evict_map), 0);
        do_lookup(16'h0050, 3'd0, 1'b0, 2'd0, "R10 replaced");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_place_empty();
        t_hit();
        t_lfu();
        t_dirty_skip();
        t_busy();
        t_dirty_vs_clean();
        t_saturate();
        t_collide();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule